// File: doc/BRIEF.md
# Compare-Channel Interval Timer

This block is a 32-bit up-counting timer that sits on a simple single-cycle register bus (address, write strobe, write data, combinational read data) and drives one interrupt line. A control register chooses whether the counter advances and how far the input clock is divided first, in powers of two. A modulo register sets the count at which the counter wraps back to zero. Writing any value to the counter register restarts the count from zero.

One compare channel watches the counter. When the channel is in software-compare mode, a status flag is set on the increment that brings the counter onto the channel's value. Software clears the flag by writing a one to it. The interrupt line is asserted while the flag is set and the channel's interrupt enable is on. A typical driver reads the live count, writes `count + delta` into the channel value, and waits for the interrupt.

Top module: `tmr_cmp_top`

## Requirements
- R1: After reset, the control, count, status, channel control and channel value registers read 0, the modulo register reads 0xFFFFFFFF, and `irq_o` is low.
- R2: The registers sit at these byte offsets: control 0x10, count 0x14, modulo 0x18, status 0x1C, channel control 0x20, channel value 0x24. Control reads back bits 4:0. Channel control reads back bits 6:2, and its other bits read 0. Modulo and channel value read back all 32 bits. Any other offset reads 0.
- R3: Control bits 4:3 hold the clock mode. With the value 01 the counter advances. With any other value the count holds.
- R4: Control bits 2:0 hold an exponent N, and the counter advances once every 2^N clocks. Once the clock mode is set to 01 from a stopped state, with the count freshly cleared, the first increment comes 2^N clock edges after the edge that wrote the control register.
- R5: Any write to the count register sets the count to 0 on that edge and restarts the prescaler phase. Reads of the count register return the live count.
- R6: An increment taken while the count equals the modulo value makes the count 0.
- R7: When channel control bits 5:2 equal 4 (software compare), status bit 0 sets on the increment that makes the count equal to the channel value.
- R8: A write to status with bit 0 set clears the flag. A write to status with bit 0 clear leaves the flag unchanged.
- R9: With any channel mode value other than 4, the flag never sets.
- R10: `irq_o` is high exactly when the flag is set and channel control bit 6 (interrupt enable) is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Compare interrupt |

## Verification
The properties assume that the bus performs at most one register write per cycle and that `bus_addr` and `bus_we` are stable around each rising edge. The bench meets this by driving all inputs on the falling edge and dropping the write strobe after exactly one rising edge. The wrap and compare properties assume that the modulo value does not drop below the live count while the counter runs. To keep within this, the stimulus stops the counter and clears it before it changes the modulo, the channel value or the prescaler. Random trials draw small modulo values so that wraps and compare hits fall inside each run window.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int OFF_CTRL  = 'h10;
  localparam int OFF_CNT   = 'h14;
  localparam int OFF_MOD   = 'h18;
  localparam int OFF_STAT  = 'h1C;
  localparam int OFF_CHCTL = 'h20;
  localparam int OFF_CHVAL = 'h24;

  localparam logic [1:0] CK_RUN   = 2'b01;
  localparam logic [3:0] CH_SWCMP = 4'h4;

  typedef struct packed {
    logic       ie;
    logic [3:0] mode;
  } ch_ctl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_mod,
  input  logic             wr_chctl,
  input  logic             wr_chval,
  input  logic [CNT_W-1:0] wdata,
  output logic [PS_W-1:0]  ps_q,
  output logic [1:0]       ck_mode_q,
  output logic [CNT_W-1:0] mod_q,
  output ch_ctl_t          ch_ctl_q,
  output logic [CNT_W-1:0] chval_q
);
  logic [PS_W-1:0]  ps_d;
  logic [1:0]       ck_mode_d;
  logic [CNT_W-1:0] mod_d;
  ch_ctl_t          ch_ctl_d;
  logic [CNT_W-1:0] chval_d;

  always_comb begin
    ps_d      = ps_q;
    ck_mode_d = ck_mode_q;
    mod_d     = mod_q;
    ch_ctl_d  = ch_ctl_q;
    chval_d   = chval_q;
    if (wr_ctrl) begin
      ps_d      = wdata[PS_W-1:0];
      ck_mode_d = wdata[PS_W+1:PS_W];
    end
    if (wr_mod)   mod_d = wdata;
    if (wr_chctl) begin
      ch_ctl_d.mode = wdata[5:2];
      ch_ctl_d.ie   = wdata[6];
    end
    if (wr_chval) chval_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q      <= '0;
      ck_mode_q <= '0;
      mod_q     <= '1;
      ch_ctl_q  <= '0;
      chval_q   <= '0;
    end else begin
      ps_q      <= ps_d;
      ck_mode_q <= ck_mode_d;
      mod_q     <= mod_d;
      ch_ctl_q  <= ch_ctl_d;
      chval_q   <= chval_d;
    end
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            clr,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;
  localparam int MSK_W = DIV_W + 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [MSK_W-1:0] one_sh;
  logic [DIV_W-1:0] mask;

  assign one_sh = MSK_W'(1) << ps;
  assign mask   = DIV_W'(one_sh - MSK_W'(1));

  always_comb begin
    div_d = div_q;
    tick  = 1'b0;
    if (clr || !run) begin
      div_d = '0;
    end else if (div_q >= mask) begin
      div_d = '0;
      tick  = 1'b1;
    end else begin
      div_d = div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] mod_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             step
);
  always_comb begin
    cnt_nxt = cnt_q;
    step    = 1'b0;
    if (clr) begin
      cnt_nxt = '0;
    end else if (tick) begin
      step    = 1'b1;
      cnt_nxt = (cnt_q == mod_val) ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ch_ctl_t          ch_ctl,
  input  logic             step,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] chval,
  input  logic             clr_req,
  output logic             flag_q,
  output logic             set_pulse,
  output logic             irq
);
  logic flag_d;

  always_comb begin
    set_pulse = step && (ch_ctl.mode == CH_SWCMP) && (cnt_nxt == chval);
    flag_d    = flag_q;
    if (clr_req)   flag_d = 1'b0;
    if (set_pulse) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign irq = flag_q && ch_ctl.ie;
endmodule

// File: rtl/tmr_cmp_top.sv
module tmr_cmp_top
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_o
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[SYNC_N-1];

  logic wr_ctrl, wr_cnt, wr_mod, wr_stat, wr_chctl, wr_chval;
  assign wr_ctrl  = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_cnt   = bus_we && (bus_addr == ADDR_W'(OFF_CNT));
  assign wr_mod   = bus_we && (bus_addr == ADDR_W'(OFF_MOD));
  assign wr_stat  = bus_we && (bus_addr == ADDR_W'(OFF_STAT));
  assign wr_chctl = bus_we && (bus_addr == ADDR_W'(OFF_CHCTL));
  assign wr_chval = bus_we && (bus_addr == ADDR_W'(OFF_CHVAL));

  logic [PS_W-1:0]  ps_q;
  logic [1:0]       ck_mode;
  logic [CNT_W-1:0] mod_q, chval_q, cnt_q, cnt_nxt;
  ch_ctl_t          ch_ctl;
  logic             tick, step, flag_q, set_pulse;
  logic [3:0]       ch_mode;
  logic             ch_ie;

  assign ch_mode = ch_ctl.mode;
  assign ch_ie   = ch_ctl.ie;

  tmr_regs #(.CNT_W(CNT_W), .PS_W(PS_W)) regs_i (
    .clk(clk), .rst_n(rst_n_s),
    .wr_ctrl(wr_ctrl), .wr_mod(wr_mod), .wr_chctl(wr_chctl), .wr_chval(wr_chval),
    .wdata(bus_wdata),
    .ps_q(ps_q), .ck_mode_q(ck_mode), .mod_q(mod_q),
    .ch_ctl_q(ch_ctl), .chval_q(chval_q)
  );

  tmr_prescaler #(.PS_W(PS_W)) pre_i (
    .clk(clk), .rst_n(rst_n_s),
    .run(ck_mode == CK_RUN), .clr(wr_cnt), .ps(ps_q), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n_s),
    .tick(tick), .clr(wr_cnt), .mod_val(mod_q),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .step(step)
  );

  tmr_channel #(.CNT_W(CNT_W)) ch_i (
    .clk(clk), .rst_n(rst_n_s),
    .ch_ctl(ch_ctl), .step(step), .cnt_nxt(cnt_nxt), .chval(chval_q),
    .clr_req(wr_stat && bus_wdata[0]),
    .flag_q(flag_q), .set_pulse(set_pulse), .irq(irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFF_CTRL):  bus_rdata = CNT_W'({ck_mode, ps_q});
      ADDR_W'(OFF_CNT):   bus_rdata = cnt_q;
      ADDR_W'(OFF_MOD):   bus_rdata = mod_q;
      ADDR_W'(OFF_STAT):  bus_rdata = CNT_W'(flag_q);
      ADDR_W'(OFF_CHCTL): bus_rdata = CNT_W'({ch_ie, ch_mode, 2'b00});
      ADDR_W'(OFF_CHVAL): bus_rdata = chval_q;
      default:            bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_cmp_chk.sv
module tmr_cmp_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [CNT_W-1:0]  bus_wdata,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  mod_q,
  input logic [1:0]        ck_mode,
  input logic [3:0]        ch_mode,
  input logic              ch_ie,
  input logic              tick,
  input logic              flag_q,
  input logic              set_pulse,
  input logic              irq_o
);
  logic cnt_wr, stat_clr;
  assign cnt_wr   = bus_we && (bus_addr == ADDR_W'(OFF_CNT));
  assign stat_clr = bus_we && (bus_addr == ADDR_W'(OFF_STAT)) && bus_wdata[0];

  assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ck_mode != CK_RUN) && !cnt_wr |=> $stable(cnt_q));

  assert_tick_gated_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    tick |-> (ck_mode == CK_RUN));

  assert_cnt_clear_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    cnt_wr |=> (cnt_q == '0));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    tick && (cnt_q == mod_q) && !cnt_wr |=> (cnt_q == '0));

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    stat_clr && !set_pulse |=> !flag_q);

  assert_flag_mode_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(flag_q) |-> $past(ch_mode == CH_SWCMP));

  assert_irq_src_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_o |-> (flag_q && ch_ie));
endmodule

bind tmr_cmp_top tmr_cmp_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n_s(rst_n_s), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .cnt_q(cnt_q), .mod_q(mod_q), .ck_mode(ck_mode),
  .ch_mode(ch_mode), .ch_ie(ch_ie), .tick(tick), .flag_q(flag_q),
  .set_pulse(set_pulse), .irq_o(irq_o)
);

// File: tb/tmr_cmp_top_tb_top.sv
module tmr_cmp_top_tb_top;
  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_chk;
  int n_fail;
  bit done;

  tmr_cmp_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_cnt(input longint ticks, input longint md);
    return 32'(ticks % (md + 1));
  endfunction

  function automatic logic exp_flag(input longint ticks, input longint md,
                                    input longint cv, input logic mode_ok);
    if (!mode_ok || cv > md) return 1'b0;
    if (cv == 0) return ticks >= md + 1;
    return ticks >= cv;
  endfunction

  task automatic setup(input int ps, input logic [31:0] md,
                       input logic [31:0] cv, input logic [31:0] chctl);
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h0);
    wr(8'h1C, 32'h1);
    wr(8'h18, md);
    wr(8'h24, cv);
    wr(8'h20, chctl);
    wr(8'h10, 32'h8 | 32'(ps));
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    n_chk = 0; n_fail = 0; done = 0;
    bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    wait_edges(5);

    // R1 reset state
    rd(8'h10, d); chk("R1 ctrl", d, 32'h0);
    rd(8'h14, d); chk("R1 cnt", d, 32'h0);
    rd(8'h18, d); chk("R1 mod", d, 32'hFFFF_FFFF);
    rd(8'h1C, d); chk("R1 stat", d, 32'h0);
    rd(8'h20, d); chk("R1 chctl", d, 32'h0);
    rd(8'h24, d); chk("R1 chval", d, 32'h0);
    chk("R1 irq", 32'(irq_o), 32'h0);

    // R2 readback and unmapped offset
    wr(8'h10, 32'hFFFF_FFE7); rd(8'h10, d); chk("R2 ctrl", d, 32'h07);
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, d); chk("R2 chctl", d, 32'h7C);
    wr(8'h20, 32'h0);
    wr(8'h24, 32'hA5A5_1234); rd(8'h24, d); chk("R2 chval", d, 32'hA5A5_1234);
    wr(8'h18, 32'h1234_5678); rd(8'h18, d); chk("R2 mod", d, 32'h1234_5678);
    rd(8'h00, d); chk("R2 unmapped", d, 32'h0);

    // R3 stopped modes hold the count
    wr(8'h10, 32'h07); wait_edges(20); rd(8'h14, d); chk("R3 mode00", d, 32'h0);
    wr(8'h10, 32'h10); wait_edges(20); rd(8'h14, d); chk("R3 mode10", d, 32'h0);

    // R4 divide by 8
    setup(3, 32'hFFFF_FFFF, 32'h0, 32'h0);
    wait_edges(7); rd(8'h14, d); chk("R4 before 8", d, 32'h0);
    wait_edges(1); rd(8'h14, d); chk("R4 at 8", d, 32'h1);

    // R5 count write clears while running
    setup(0, 32'hFFFF_FFFF, 32'h0, 32'h0);
    wait_edges(9);
    wr(8'h14, 32'h1234); rd(8'h14, d); chk("R5 clear", d, 32'h0);
    // R3 stop after run holds value
    wait_edges(4);
    wr(8'h10, 32'h0); rd(8'h14, d);
    wait_edges(10); rd(8'h14, d2); chk("R3 stop hold", d2, d);

    // R6 wrap at modulo
    setup(0, 32'd5, 32'h0, 32'h0);
    wait_edges(6); rd(8'h14, d); chk("R6 wrap", d, 32'h0);
    wait_edges(1); rd(8'h14, d); chk("R6 after wrap", d, 32'h1);

    // R7 R10 compare sets flag and irq
    setup(0, 32'hFFFF_FFFF, 32'd3, 32'h50);
    wait_edges(2); rd(8'h1C, d); chk("R7 before match", d, 32'h0);
    wait_edges(1); rd(8'h1C, d); chk("R7 match", d, 32'h1);
    chk("R10 irq on", 32'(irq_o), 32'h1);
    // R8 write-one-to-clear
    wr(8'h1C, 32'hFFFF_FFFE); rd(8'h1C, d); chk("R8 write0 keeps", d, 32'h1);
    wr(8'h1C, 32'h1); rd(8'h1C, d); chk("R8 write1 clears", d, 32'h0);
    chk("R10 irq off", 32'(irq_o), 32'h0);

    // R9 disabled channel never flags
    setup(0, 32'hFFFF_FFFF, 32'd3, 32'h40);
    wait_edges(10); rd(8'h1C, d); chk("R9 no flag", d, 32'h0);
    chk("R9 no irq", 32'(irq_o), 32'h0);

    // R10 interrupt enable off
    setup(0, 32'hFFFF_FFFF, 32'd2, 32'h10);
    wait_edges(5); rd(8'h1C, d); chk("R10 flag ie0", d, 32'h1);
    chk("R10 irq masked", 32'(irq_o), 32'h0);

    // random trials: R4 R6 R7 R9 R10
    void'($urandom(32'd1234));
    for (int i = 0; i < 25; i++) begin
      int ps, w;
      logic [31:0] md, cv, ctl;
      logic mode_ok, ie, ef;
      longint ticks;
      ps = int'($urandom % 4);
      md = 32'd2 + ($urandom % 30);
      cv = $urandom % (md + 3);
      mode_ok = ($urandom % 4) != 0;
      ie = 1'($urandom % 2);
      ctl = {25'h0, ie, (mode_ok ? 4'h4 : 4'(1 + $urandom % 3)), 2'b00};
      w = int'($urandom % 200);
      setup(ps, md, cv, ctl);
      wait_edges(w);
      ticks = longint'(w / (1 << ps));
      ef = exp_flag(ticks, longint'(md), longint'(cv), mode_ok);
      rd(8'h14, d); chk("R6 rnd count", d, exp_cnt(ticks, longint'(md)));
      rd(8'h1C, d); chk("R7 rnd flag", d, 32'(ef));
      chk("R10 rnd irq", 32'(irq_o), 32'(ef & ie));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule